// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

The block turns a 10-bit parallel word into a 12-bit serial frame that carries its own clock marks. A high start bit and a low stop bit are wrapped around the payload. The rising transition at the start of every frame gives a receiver one fixed reference edge per word. All logic runs on the fast bit clock `clk_i`, which runs at twelve times the word rate. The word clock `wclk_i` is sampled in that domain, and a mode input picks which of its edges captures `din_i`. Each captured frame is then held stable and sent out one bit per bit-clock cycle, so the line carries twelve bits per word period, ten of them payload.

Two sync-request inputs let a link partner ask for training frames. These frames have one rising transition and no payload. Driving power-down low darkens the output and restarts a fixed initialisation interval, counted in word-clock edges. The enable input only gates the line: while it is low, `valid_o` models a high-impedance driver.

Top module: `embclk_serializer`

## Requirements
- R1: A payload frame is sent LSB first, one bit per bit clock. Frame bit 0 is the start bit, always 1. Bits 1 to 10 carry `din_i[0]` to `din_i[9]`. Bit 11 is the stop bit, always 0.
- R2: The frame captured on a selected word-clock edge is held for 12 bit clocks. Its start bit appears in the bit-clock cycle after the edge is sampled. If selected edges arrive every 12 bit clocks, frames follow back to back with no gap.
- R3: When `edge_rise_i` is 1, rising edges of `wclk_i` capture `din_i`. When it is 0, falling edges capture. Edges of the other polarity capture nothing.
- R4: A selected edge sends a sync frame instead of payload when it is at least the 5th consecutive selected edge with `sync_a_i` or `sync_b_i` high. A sync frame has bits 0 to 5 at 1 and bits 6 to 11 at 0. A run of only 4 such edges still sends payload.
- R5: Sync frames continue while either sync input stays high, even if the high input changes from one to the other. The first selected edge with both sync inputs low sends payload again and restarts the count.
- R6: While `en_i` is low, `valid_o` and `ser_o` are 0 in the same cycle.
- R7: While `pwrdn_ni` is low, `valid_o` and `ser_o` are 0 in the same cycle. No word is captured, and the sync count is cleared.
- R8: After reset, and after `pwrdn_ni` is released, the first INIT_WORDS (510) selected edges capture nothing and `valid_o` stays 0. The next selected edge captures.
- R9: During reset, `valid_o` and `ser_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 12x word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word clock, synchronous to clk_i |
| edge_rise_i | input | 1 | 1: capture on rising edge, 0: on falling edge |
| din_i | input | 10 | Parallel payload word |
| sync_a_i | input | 1 | Sync request, first source |
| sync_b_i | input | 1 | Sync request, second source |
| en_i | input | 1 | Line driver enable |
| pwrdn_ni | input | 1 | Power-down, active low |
| ser_o | output | 1 | Serial line bit |
| valid_o | output | 1 | Line driven; 0 models high impedance |

## Verification
The embedded assertions watch, on every cycle, properties that need no scenario:
- the held frame stays stable between loads;
- the bit index steps once per bit clock;
- start and stop bits sit where a receiver expects them;
- the initialisation count reloads during power-down and ready never falls while power is on;
- the sync count clears on an edge with no request;
- the line stays dark after power-down.

Some behaviour only the bench scenarios can show. These are the exact payload bit mapping, rejection of decoy data placed on the unselected edge, the fourth-versus-fifth edge threshold for sync, and the handover between the two sync inputs. They also include the exact 510/511 boundary of initialisation after both reset and power-down.

// File: rtl/embclk_ser_pkg.sv
package embclk_ser_pkg;
  localparam int unsigned PAYLOAD_W = 10;
  localparam int unsigned FRAME_W   = PAYLOAD_W + 2;
  localparam int unsigned IDX_W     = $clog2(FRAME_W);

  typedef logic [FRAME_W-1:0] frame_t;

  // bit 0 leaves first: start=1, payload LSB first, stop=0
  function automatic frame_t data_frame(input logic [PAYLOAD_W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  // first half ones, second half zeros: one rising transition per frame
  function automatic frame_t sync_frame();
    frame_t f;
    for (int unsigned i = 0; i < FRAME_W; i++) f[i] = (i < FRAME_W / 2);
    return f;
  endfunction
endpackage

// File: rtl/embclk_wclk_edge.sv
module embclk_wclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wclk_i,
  input  logic edge_rise_i,
  output logic strobe_o
);
  logic wclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wclk_q <= 1'b0;
    else         wclk_q <= wclk_i;
  end

  logic rise, fall;
  assign rise     = wclk_i & ~wclk_q;
  assign fall     = ~wclk_i & wclk_q;
  assign strobe_o = edge_rise_i ? rise : fall;

  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/embclk_sync_ctrl.sv
module embclk_sync_ctrl #(
  parameter int unsigned SYNC_WORDS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic pwrdn_ni,
  input  logic sync_a_i,
  input  logic sync_b_i,
  output logic sync_now_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SYNC_WORDS);

  logic [CNT_W-1:0] cnt_q;
  logic             req;

  assign req        = sync_a_i | sync_b_i;
  assign sync_now_o = strobe_i & req & (cnt_q >= CNT_MAX - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!pwrdn_ni)         cnt_q <= '0;
    else if (strobe_i) begin
      if (!req)                 cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_sync_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && pwrdn_ni && !req) |=> cnt_q == '0);
  assert_sync_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_sync_pd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |=> cnt_q == '0);
endmodule

// File: rtl/embclk_init_ctrl.sv
module embclk_init_ctrl #(
  parameter int unsigned INIT_WORDS = 510
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic pwrdn_ni,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(INIT_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_WORDS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CNT_INIT;
    else if (!pwrdn_ni)               cnt_q <= CNT_INIT;
    else if (strobe_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ready_o = (cnt_q == '0);

  assert_init_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |=> cnt_q == CNT_INIT);
  assert_ready_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && pwrdn_ni) |=> ready_o);
  assert_init_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_INIT);
endmodule

// File: rtl/embclk_frame_shifter.sv
module embclk_frame_shifter
  import embclk_ser_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  frame_t frame_i,
  input  logic   pwrdn_ni,
  output logic   bit_o,
  output logic   active_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  frame_t           frame_q;
  logic [IDX_W-1:0] idx_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      idx_q   <= LAST;
    end else if (load_i) begin
      frame_q <= frame_i;
      idx_q   <= '0;
    end else if (idx_q != LAST) begin
      idx_q   <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (!pwrdn_ni) active_q <= 1'b0;
    else if (load_i)    active_q <= 1'b1;
  end

  assign bit_o    = frame_q[idx_q];
  assign active_o = active_q;

  assert_frame_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(frame_q));
  assert_bit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && idx_q != LAST) |=> idx_q == $past(idx_q) + IDX_W'(1));
  assert_start_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q == '0) |-> frame_q[0]);
  assert_stop_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q == LAST) |-> !frame_q[FRAME_W-1]);
endmodule

// File: rtl/embclk_serializer.sv
module embclk_serializer
  import embclk_ser_pkg::*;
#(
  parameter int unsigned INIT_WORDS = 510,
  parameter int unsigned SYNC_WORDS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wclk_i,
  input  logic                 edge_rise_i,
  input  logic [PAYLOAD_W-1:0] din_i,
  input  logic                 sync_a_i,
  input  logic                 sync_b_i,
  input  logic                 en_i,
  input  logic                 pwrdn_ni,
  output logic                 ser_o,
  output logic                 valid_o
);
  logic   strobe, sync_now, ready, load, line_bit, active;
  frame_t next_frame;

  embclk_wclk_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wclk_i      (wclk_i),
    .edge_rise_i (edge_rise_i),
    .strobe_o    (strobe)
  );

  embclk_sync_ctrl #(.SYNC_WORDS(SYNC_WORDS)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .pwrdn_ni   (pwrdn_ni),
    .sync_a_i   (sync_a_i),
    .sync_b_i   (sync_b_i),
    .sync_now_o (sync_now)
  );

  embclk_init_ctrl #(.INIT_WORDS(INIT_WORDS)) u_init (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .pwrdn_ni (pwrdn_ni),
    .ready_o  (ready)
  );

  assign load       = strobe & ready & pwrdn_ni;
  assign next_frame = sync_now ? sync_frame() : data_frame(din_i);

  embclk_frame_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .frame_i  (next_frame),
    .pwrdn_ni (pwrdn_ni),
    .bit_o    (line_bit),
    .active_o (active)
  );

  assign valid_o = en_i & pwrdn_ni & active;
  assign ser_o   = valid_o & line_bit;

  assert_start_on_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (!valid_o || ser_o));
  assert_dark_after_pd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |=> !valid_o);
  assert_quiet_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !ser_o);
endmodule

// File: tb/test_embclk_serializer.sv
module test_embclk_serializer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wclk = 1'b0, edge_rise = 1'b1;
  logic [9:0] din = '0;
  logic       sync_a = 1'b0, sync_b = 1'b0, en = 1'b1, pwrdn_n = 1'b1;
  logic       ser_o, valid_o;

  always #10 clk = ~clk;

  embclk_serializer i_embclk_serializer (
    .clk_i(clk), .rst_ni(rst_ni), .wclk_i(wclk), .edge_rise_i(edge_rise),
    .din_i(din), .sync_a_i(sync_a), .sync_b_i(sync_b), .en_i(en),
    .pwrdn_ni(pwrdn_n), .ser_o(ser_o), .valid_o(valid_o)
  );

  localparam int NV = 20;
  // {din[23:14], decoy[13:4], sync_a[3], sync_b[2], en[1], pwrdn_n[0]}
  localparam logic [23:0] VEC [NV] = '{
    {10'h2A5, 10'h15A, 4'b0011}, {10'h000, 10'h3FF, 4'b0011},
    {10'h3FF, 10'h000, 4'b0011}, {10'h155, 10'h2AA, 4'b0011},
    {10'h123, 10'h0DC, 4'b0001}, {10'h0F0, 10'h30F, 4'b0011},
    {10'h111, 10'h000, 4'b1011}, {10'h222, 10'h000, 4'b1011},
    {10'h333, 10'h000, 4'b1011}, {10'h044, 10'h000, 4'b1011},
    {10'h055, 10'h000, 4'b0011}, {10'h066, 10'h000, 4'b1011},
    {10'h077, 10'h000, 4'b1011}, {10'h088, 10'h000, 4'b1011},
    {10'h099, 10'h000, 4'b1011}, {10'h0AA, 10'h000, 4'b1011},
    {10'h0BB, 10'h000, 4'b1111}, {10'h0CC, 10'h000, 4'b0111},
    {10'h3C3, 10'h000, 4'b0011}, {10'h1E1, 10'h21E, 4'b0011}
  };
  localparam string TAGS [NV] = '{
    "R8 R1", "R1 R2", "R1 R2", "R1", "R6", "R6 R2",
    "R4", "R4", "R4", "R4 r4_fourth", "R5", "R4", "R4", "R4", "R4",
    "R4 fifth", "R5", "R5 handover", "R5 release", "R2"
  };

  int n_vec = 0, n_bad = 0;
  int init_left, scnt;
  logic [11:0] exp_bits;
  logic        exp_v;
  string       exp_tag;

  task automatic model_reset();
    init_left = 510; scnt = 0; exp_bits = '0; exp_v = 1'b0; exp_tag = "R9";
  endtask

  // one word period: check the frame launched last period, launch a new one
  task automatic run_word(input logic [9:0] d, input logic [9:0] dec,
                          input logic sa, input logic sb, input logic e,
                          input logic pd, input string tag);
    logic [11:0] rb, rv;
    logic        any, snow;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rb[i] = ser_o; rv[i] = valid_o;
      if (i == 5) begin wclk = ~edge_rise; din = dec; end
      if (i == 11) begin
        wclk = edge_rise; din = d; sync_a = sa; sync_b = sb; en = e; pwrdn_n = pd;
      end
    end
    n_vec++;
    if (rb !== (exp_v ? exp_bits : 12'h000) || rv !== {12{exp_v}}) begin
      n_bad++;
      $display("FAIL %s: bits %h valid %h, expected bits %h valid %h",
               exp_tag, rb, rv, exp_v ? exp_bits : 12'h000, {12{exp_v}});
    end
    exp_tag = tag;
    if (!pd) begin
      init_left = 510; scnt = 0; exp_v = 1'b0;
    end else begin
      any  = sa | sb;
      scnt = any ? ((scnt < 5) ? scnt + 1 : 5) : 0;
      snow = any && (scnt == 5);
      if (init_left > 0) begin
        init_left--; exp_v = 1'b0;
      end else begin
        exp_bits = snow ? 12'h03F : {1'b0, d, 1'b1};
        exp_v    = e;
      end
    end
  endtask

  task automatic do_reset(input logic rise);
    edge_rise = rise; rst_ni = 1'b0; wclk = ~rise;
    sync_a = 0; sync_b = 0; en = 1; pwrdn_n = 1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (valid_o !== 1'b0 || ser_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: valid %b ser %b, expected 0 0", valid_o, ser_o);
    end
    rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic run_init(input string tag);
    for (int k = 0; k < 510; k++)
      run_word(10'(k * 37), 10'(~(k * 37)), 1'b0, 1'b0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    run_init("R8");
    for (int v = 0; v < NV; v++)
      run_word(VEC[v][23:14], VEC[v][13:4], VEC[v][3], VEC[v][2],
               VEC[v][1], VEC[v][0], TAGS[v]);
    // power-down, then re-initialisation after release
    run_word(10'h2F0, 10'h10F, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    run_word(10'h2F1, 10'h10E, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    run_init("R8 post-pd");
    run_word(10'h19B, 10'h264, 1'b0, 1'b0, 1'b1, 1'b1, "R8 boundary");
    run_word(10'h3A0, 10'h05F, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
    // falling-edge capture with decoy data on rising edges
    do_reset(1'b0);
    run_init("R8");
    run_word(10'h3E1, 10'h01E, 1'b0, 1'b0, 1'b1, 1'b1, "R3 fall");
    run_word(10'h00F, 10'h3F0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 fall");
    run_word(10'h2D2, 10'h12D, 1'b0, 1'b1, 1'b1, 1'b1, "R3 fall");
    run_word(10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule